// File: doc/BRIEF.md
# Load/Store Ordering Queue with Store-to-Load Forwarding

This block keeps the memory operations of an out-of-order core in program order. Every load and store takes a slot when it is allocated. The slots fill in a fixed circular order, so the distance of a slot from the head pointer gives its age. Address generation writes each operation's address into its slot at some later time. Stores also receive their data at some later time. Operations leave the queue only from the head, in program order, and a store writes the data cache only when it leaves.

An issue stage asks about a load by giving the load's slot index. The block replies combinationally with three things. The first is whether an older store still has an unknown address; if so, the load must wait. The second is whether an older store with a known address matches the load's address; the youngest such store supplies the load's value, and that value overrides the data-cache value that comes in on a separate input. The third is whether that matching store still lacks its data; if so, the load must stall rather than read the cache. The search measures age from the head pointer, so it gives the same answers after the pointers have wrapped.

Top module: `ldst_queue`

## Requirements
- R1: After reset the queue is empty: `alloc_ready` is 1, `head_valid` is 0 and `alloc_idx` is 0.
- R2: Slots are handed out in ascending index order modulo DEPTH, one per accepted `alloc_valid` cycle. `alloc_ready` is 0 while all DEPTH slots are occupied, and an allocation request made while full changes nothing.
- R3: When `retire_req` is high and `head_ready` is high, the head slot is released and the head moves to the next slot. `head_ready` is 1 only when the head slot is occupied, its address is known, and (for a store) its data is known. Without `head_ready`, `retire_req` has no effect.
- R4: In the retiring cycle of a store, `cache_wr_en` is 1 and `cache_wr_addr`/`cache_wr_data` carry that store's address and data. The retirement of a load leaves `cache_wr_en` at 0.
- R5: `qry_wait_addr` is 1 exactly when some occupied store slot older than the queried load has no known address.
- R6: When one or more older stores with known addresses equal the load's address, `qry_fwd_hit` is 1 and `qry_data` equals the data of the youngest of them.
- R7: With no matching older store, `qry_fwd_hit` is 0 and `qry_data` equals `cache_rd_data`.
- R8: When the selected matching store has no data yet, `qry_wait_data` is 1 and `qry_go` is 0. Once the data is written, `qry_data` returns it.
- R9: Stores younger than the queried load never affect the query. Age is counted from the head pointer, so selection is correct when the occupied slots wrap past index DEPTH-1.
- R10: Address or data writes aimed at a free slot are dropped. Allocating a slot marks its address and data as unknown.
- R11: `qry_go` is 1 only for an occupied load slot whose own address is known, with neither wait condition present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate a slot at the tail |
| alloc_is_store | input | 1 | 1 = store, 0 = load, for the allocation |
| alloc_ready | output | 1 | A free slot exists |
| alloc_idx | output | IW | Slot index the next allocation receives |
| addr_valid | input | 1 | Address write strobe |
| addr_idx | input | IW | Slot receiving the address |
| addr_value | input | AW | Address value |
| data_valid | input | 1 | Store data write strobe |
| data_idx | input | IW | Slot receiving the data |
| data_value | input | DW | Store data value |
| qry_idx | input | IW | Slot of the load being queried |
| cache_rd_data | input | DW | Data-cache value for the load's address |
| qry_wait_addr | output | 1 | Older store has an unknown address |
| qry_fwd_hit | output | 1 | Older matching store found |
| qry_wait_data | output | 1 | Selected store has no data yet |
| qry_go | output | 1 | Load may complete with `qry_data` |
| qry_data | output | DW | Forwarded data or cache data |
| retire_req | input | 1 | Request to retire the head |
| head_valid | output | 1 | Head slot occupied |
| head_ready | output | 1 | Head slot may retire |
| head_is_store | output | 1 | Head slot holds a store |
| cache_wr_en | output | 1 | Retiring store writes the cache |
| cache_wr_addr | output | AW | Cache write address |
| cache_wr_data | output | DW | Cache write data |

## Verification
A corrupted age computation or a selection loop that runs in the wrong direction shows up in the same cycle as the query. `qry_data` then carries an older store's value, or a younger store's value, where the youngest older one is required. A lost valid or address-known bit shows up as a wrong `qry_wait_addr` on the next query, or as a stuck `head_ready` at retirement. Pointer errors show up within one allocation or retirement through `alloc_idx`, `alloc_ready` or `cache_wr_addr`. The bench therefore sweeps every head offset against every mix of older stores and loads on two addresses.

// File: rtl/ldst_queue_pkg.sv
package ldst_queue_pkg;
   typedef enum logic {
      OP_LOAD  = 1'b0,
      OP_STORE = 1'b1
   } mem_op_e;

   function automatic int unsigned idx_width(input int unsigned depth);
      return (depth > 1) ? $clog2(depth) : 1;
   endfunction
endpackage

// File: rtl/ldst_queue_ptrs.sv
module ldst_queue_ptrs #(
   parameter int unsigned DEPTH = 8,
   localparam int unsigned IW = ldst_queue_pkg::idx_width(DEPTH),
   localparam int unsigned CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   output logic [IW-1:0] hd_ptr,
   output logic [IW-1:0] tl_ptr,
   output logic          full,
   output logic          empty
);
   logic [CW-1:0] occ;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hd_ptr <= '0;
         tl_ptr <= '0;
         occ    <= '0;
      end else begin
         if (push) tl_ptr <= tl_ptr + 1'b1;
         if (pop)  hd_ptr <= hd_ptr + 1'b1;
         case ({push, pop})
            2'b10:   occ <= occ + 1'b1;
            2'b01:   occ <= occ - 1'b1;
            default: occ <= occ;
         endcase
      end
   end

   assign full  = (occ == CW'(DEPTH));
   assign empty = (occ == '0);
endmodule

// File: rtl/ldst_queue_slots.sv
module ldst_queue_slots #(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned AW    = 32,
   parameter int unsigned DW    = 32,
   localparam int unsigned IW = ldst_queue_pkg::idx_width(DEPTH)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     push,
   input  logic [IW-1:0]            push_slot,
   input  logic                     push_st,
   input  logic                     pop,
   input  logic [IW-1:0]            pop_slot,
   input  logic                     aw_en,
   input  logic [IW-1:0]            aw_slot,
   input  logic [AW-1:0]            aw_val,
   input  logic                     dw_en,
   input  logic [IW-1:0]            dw_slot,
   input  logic [DW-1:0]            dw_val,
   output logic [DEPTH-1:0]         occ_v,
   output logic [DEPTH-1:0]         is_st,
   output logic [DEPTH-1:0]         adr_known,
   output logic [DEPTH-1:0]         dat_known,
   output logic [DEPTH-1:0][AW-1:0] adr,
   output logic [DEPTH-1:0][DW-1:0] dat
);
   import ldst_queue_pkg::*;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic take, drop, a_hit, d_hit;
      assign take  = push && (push_slot == IW'(i));
      assign drop  = pop  && (pop_slot  == IW'(i));
      assign a_hit = aw_en && (aw_slot == IW'(i)) && occ_v[i];
      assign d_hit = dw_en && (dw_slot == IW'(i)) && occ_v[i] && is_st[i];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            occ_v[i]     <= 1'b0;
            is_st[i]     <= OP_LOAD;
            adr_known[i] <= 1'b0;
            dat_known[i] <= 1'b0;
         end else if (take) begin
            occ_v[i]     <= 1'b1;
            is_st[i]     <= push_st;
            adr_known[i] <= 1'b0;
            dat_known[i] <= 1'b0;
         end else if (drop) begin
            occ_v[i]     <= 1'b0;
            adr_known[i] <= 1'b0;
            dat_known[i] <= 1'b0;
         end else begin
            if (a_hit) adr_known[i] <= 1'b1;
            if (d_hit) dat_known[i] <= 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (a_hit && !drop) adr[i] <= aw_val;
         if (d_hit && !drop) dat[i] <= dw_val;
      end
   end
endmodule

// File: rtl/ldst_queue_search.sv
module ldst_queue_search #(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned AW    = 32,
   parameter int unsigned DW    = 32,
   localparam int unsigned IW = ldst_queue_pkg::idx_width(DEPTH)
) (
   input  logic [IW-1:0]            hd_ptr,
   input  logic [IW-1:0]            q_slot,
   input  logic [DEPTH-1:0]         occ_v,
   input  logic [DEPTH-1:0]         is_st,
   input  logic [DEPTH-1:0]         adr_known,
   input  logic [DEPTH-1:0]         dat_known,
   input  logic [DEPTH-1:0][AW-1:0] adr,
   input  logic [DEPTH-1:0][DW-1:0] dat,
   output logic                     unk_older,
   output logic                     match,
   output logic                     match_dat_ok,
   output logic [DW-1:0]            match_dat
);
   logic [IW-1:0] q_age, c_slot, c_age, sel;

   // Walk from the oldest candidate toward the load; later hits overwrite
   // earlier ones, so the youngest older matching store wins.
   always_comb begin
      q_age     = q_slot - hd_ptr;
      unk_older = 1'b0;
      match     = 1'b0;
      sel       = '0;
      c_slot    = '0;
      c_age     = '0;
      for (int k = DEPTH - 1; k >= 1; k--) begin
         c_slot = q_slot - IW'(k);
         c_age  = c_slot - hd_ptr;
         if (occ_v[c_slot] && is_st[c_slot] && (c_age < q_age)) begin
            if (!adr_known[c_slot]) begin
               unk_older = 1'b1;
            end else if (adr[c_slot] == adr[q_slot]) begin
               match = 1'b1;
               sel   = c_slot;
            end
         end
      end
   end

   assign match_dat    = dat[sel];
   assign match_dat_ok = dat_known[sel];
endmodule

// File: rtl/ldst_queue.sv
module ldst_queue #(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned AW    = 32,
   parameter int unsigned DW    = 32,
   localparam int unsigned IW = ldst_queue_pkg::idx_width(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          alloc_valid,
   input  logic          alloc_is_store,
   output logic          alloc_ready,
   output logic [IW-1:0] alloc_idx,
   input  logic          addr_valid,
   input  logic [IW-1:0] addr_idx,
   input  logic [AW-1:0] addr_value,
   input  logic          data_valid,
   input  logic [IW-1:0] data_idx,
   input  logic [DW-1:0] data_value,
   input  logic [IW-1:0] qry_idx,
   input  logic [DW-1:0] cache_rd_data,
   output logic          qry_wait_addr,
   output logic          qry_fwd_hit,
   output logic          qry_wait_data,
   output logic          qry_go,
   output logic [DW-1:0] qry_data,
   input  logic          retire_req,
   output logic          head_valid,
   output logic          head_ready,
   output logic          head_is_store,
   output logic          cache_wr_en,
   output logic [AW-1:0] cache_wr_addr,
   output logic [DW-1:0] cache_wr_data
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("ldst_queue: DEPTH must be a power of two, at least 2");
   end
   if (AW < 1 || DW < 1) begin : g_bad_width
      $error("ldst_queue: AW and DW must be at least 1");
   end

   logic [IW-1:0]            hd_ptr, tl_ptr;
   logic                     full, empty, push, pop;
   logic [DEPTH-1:0]         occ_v, is_st, adr_known, dat_known;
   logic [DEPTH-1:0][AW-1:0] adr;
   logic [DEPTH-1:0][DW-1:0] dat;
   logic                     unk_older, match, match_dat_ok;
   logic [DW-1:0]            match_dat;
   logic                     q_load_ok;

   assign push = alloc_valid && !full;
   assign pop  = retire_req && head_ready;

   ldst_queue_ptrs #(.DEPTH(DEPTH)) u_ptrs (
      .clk    (clk),
      .rst_n  (rst_n),
      .push   (push),
      .pop    (pop),
      .hd_ptr (hd_ptr),
      .tl_ptr (tl_ptr),
      .full   (full),
      .empty  (empty)
   );

   ldst_queue_slots #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_slots (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_slot (tl_ptr),
      .push_st   (alloc_is_store),
      .pop       (pop),
      .pop_slot  (hd_ptr),
      .aw_en     (addr_valid),
      .aw_slot   (addr_idx),
      .aw_val    (addr_value),
      .dw_en     (data_valid),
      .dw_slot   (data_idx),
      .dw_val    (data_value),
      .occ_v     (occ_v),
      .is_st     (is_st),
      .adr_known (adr_known),
      .dat_known (dat_known),
      .adr       (adr),
      .dat       (dat)
   );

   ldst_queue_search #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_search (
      .hd_ptr       (hd_ptr),
      .q_slot       (qry_idx),
      .occ_v        (occ_v),
      .is_st        (is_st),
      .adr_known    (adr_known),
      .dat_known    (dat_known),
      .adr          (adr),
      .dat          (dat),
      .unk_older    (unk_older),
      .match        (match),
      .match_dat_ok (match_dat_ok),
      .match_dat    (match_dat)
   );

   assign alloc_ready   = !full;
   assign alloc_idx     = tl_ptr;

   assign q_load_ok     = occ_v[qry_idx] && !is_st[qry_idx] && adr_known[qry_idx];
   assign qry_wait_addr = unk_older;
   assign qry_fwd_hit   = match && adr_known[qry_idx];
   assign qry_wait_data = qry_fwd_hit && !match_dat_ok;
   assign qry_data      = qry_fwd_hit ? match_dat : cache_rd_data;
   assign qry_go        = q_load_ok && !unk_older && !qry_wait_data;

   assign head_valid    = !empty && occ_v[hd_ptr];
   assign head_is_store = is_st[hd_ptr];
   assign head_ready    = head_valid && adr_known[hd_ptr] &&
                          (!is_st[hd_ptr] || dat_known[hd_ptr]);
   assign cache_wr_en   = pop && is_st[hd_ptr];
   assign cache_wr_addr = adr[hd_ptr];
   assign cache_wr_data = dat[hd_ptr];
endmodule

// File: rtl/ldst_queue_chk.sv
module ldst_queue_chk #(
   parameter int unsigned DEPTH = 8,
   localparam int unsigned IW = ldst_queue_pkg::idx_width(DEPTH)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          alloc_valid,
   input logic          alloc_ready,
   input logic [IW-1:0] alloc_idx,
   input logic          retire_req,
   input logic          head_valid,
   input logic          head_ready,
   input logic [IW-1:0] hd_ptr,
   input logic          cache_wr_en,
   input logic          qry_wait_addr,
   input logic          qry_fwd_hit,
   input logic          qry_wait_data,
   input logic          qry_go
);
   a_r2_alloc_advances: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_valid && alloc_ready) |=> (alloc_idx == $past(alloc_idx) + 1'b1));

   a_r2_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!alloc_ready && !(retire_req && head_ready)) |=> !alloc_ready);

   a_r3_head_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !(retire_req && head_ready) |=> $stable(hd_ptr));

   a_r3_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      head_ready |-> head_valid);

   a_r4_write_on_retire: assert property (@(posedge clk) disable iff (!rst_n)
      cache_wr_en |-> (retire_req && head_ready));

   a_r8_wait_data_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
      qry_wait_data |-> (qry_fwd_hit && !qry_go));

   a_r11_go_clear: assert property (@(posedge clk) disable iff (!rst_n)
      qry_go |-> (!qry_wait_addr && !qry_wait_data));
endmodule

bind ldst_queue ldst_queue_chk #(.DEPTH(DEPTH)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .alloc_valid   (alloc_valid),
   .alloc_ready   (alloc_ready),
   .alloc_idx     (alloc_idx),
   .retire_req    (retire_req),
   .head_valid    (head_valid),
   .head_ready    (head_ready),
   .hd_ptr        (hd_ptr),
   .cache_wr_en   (cache_wr_en),
   .qry_wait_addr (qry_wait_addr),
   .qry_fwd_hit   (qry_fwd_hit),
   .qry_wait_data (qry_wait_data),
   .qry_go        (qry_go)
);

// File: tb/ldst_queue_tb.sv
`timescale 1ns/1ps
module ldst_queue_tb;
   localparam int DEPTH = 4;
   localparam int AW = 4;
   localparam int DW = 8;
   localparam int IW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic alloc_valid = 0, alloc_is_store = 0, addr_valid = 0, data_valid = 0, retire_req = 0;
   logic [IW-1:0] addr_idx = '0, data_idx = '0, qry_idx = '0;
   logic [AW-1:0] addr_value = '0;
   logic [DW-1:0] data_value = '0, cache_rd_data = 8'hC5;
   logic alloc_ready, qry_wait_addr, qry_fwd_hit, qry_wait_data, qry_go;
   logic head_valid, head_ready, head_is_store, cache_wr_en;
   logic [IW-1:0] alloc_idx;
   logic [DW-1:0] qry_data, cache_wr_data;
   logic [AW-1:0] cache_wr_addr;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   ldst_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .alloc_valid(alloc_valid), .alloc_is_store(alloc_is_store),
      .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
      .addr_valid(addr_valid), .addr_idx(addr_idx), .addr_value(addr_value),
      .data_valid(data_valid), .data_idx(data_idx), .data_value(data_value),
      .qry_idx(qry_idx), .cache_rd_data(cache_rd_data),
      .qry_wait_addr(qry_wait_addr), .qry_fwd_hit(qry_fwd_hit),
      .qry_wait_data(qry_wait_data), .qry_go(qry_go), .qry_data(qry_data),
      .retire_req(retire_req), .head_valid(head_valid), .head_ready(head_ready),
      .head_is_store(head_is_store), .cache_wr_en(cache_wr_en),
      .cache_wr_addr(cache_wr_addr), .cache_wr_data(cache_wr_data)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
   endtask

   task automatic do_alloc(input logic st, output logic [IW-1:0] idx);
      @(negedge clk);
      alloc_valid = 1; alloc_is_store = st;
      #1 idx = alloc_idx;
      @(posedge clk); #1 alloc_valid = 0;
   endtask

   task automatic do_write(input logic [IW-1:0] s, input logic wa, input logic [AW-1:0] a,
                           input logic wd, input logic [DW-1:0] d);
      @(negedge clk);
      addr_valid = wa; addr_idx = s; addr_value = a;
      data_valid = wd; data_idx = s; data_value = d;
      @(posedge clk); #1 addr_valid = 0; data_valid = 0;
   endtask

   task automatic do_retire(output logic wr, output logic [AW-1:0] wa, output logic [DW-1:0] wd);
      @(negedge clk);
      retire_req = 1;
      #1 wr = cache_wr_en; wa = cache_wr_addr; wd = cache_wr_data;
      @(posedge clk); #1 retire_req = 0;
   endtask

   task automatic settle();
      @(negedge clk); #1;
   endtask

   initial begin
      #400000;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [IW-1:0] s0, s1, s2, s3, lq;
      logic wr;
      logic [AW-1:0] wa;
      logic [DW-1:0] wd;

      // R1 reset state
      do_reset();
      settle();
      check("R1 alloc_ready", alloc_ready, 1);
      check("R1 head_valid", head_valid, 0);
      check("R1 alloc_idx", alloc_idx, 0);

      // R10 write to free slot dropped, R5 unknown older store address
      do_write(2'd2, 1, 4'h3, 1, 8'h77);
      do_alloc(0, s0); do_write(s0, 1, 4'h1, 0, 0);
      do_alloc(0, s1); do_write(s1, 1, 4'h2, 0, 0);
      do_alloc(1, s2);
      do_alloc(0, lq); do_write(lq, 1, 4'h3, 0, 0);
      check("R2 slot order", {s0, s1, s2, lq}, 8'b00_01_10_11);
      qry_idx = lq; settle();
      check("R10 free-slot write dropped, R5 wait_addr", qry_wait_addr, 1);
      check("R11 go blocked by R5", qry_go, 0);
      // R2 full
      check("R2 full alloc_ready", alloc_ready, 0);
      do_alloc(1, s3);
      check("R2 full alloc_idx unchanged", alloc_idx, 0);
      do_write(s2, 1, 4'h9, 1, 8'h5E);
      settle();
      check("R7 no match fwd_hit", qry_fwd_hit, 0);
      check("R7 cache data", qry_data, 8'hC5);
      check("R11 go", qry_go, 1);
      // R3 retire loads: no cache write
      do_retire(wr, wa, wd);
      check("R4 load retire no write", wr, 0);
      check("R2 ready after retire", alloc_ready, 1);
      do_alloc(1, s3);
      check("R2 wrap to slot 0", s3, 0);
      do_write(s3, 1, 4'h3, 1, 8'hAB);
      // s3 is younger than lq: no effect (R9)
      settle();
      check("R9 younger store ignored", qry_fwd_hit, 0);
      do_retire(wr, wa, wd);
      settle();
      check("R3 head is store", head_is_store, 1);
      // head store s2 known: retire it
      do_retire(wr, wa, wd);
      check("R4 store write en", wr, 1);
      check("R4 store write addr", wa, 4'h9);
      check("R4 store write data", wd, 8'h5E);

      // R8 stall on missing data, R3 retire blocked
      do_reset();
      do_alloc(1, s0); do_write(s0, 1, 4'h3, 0, 0);
      do_alloc(0, lq); do_write(lq, 1, 4'h3, 0, 0);
      qry_idx = lq; settle();
      check("R8 wait_data", qry_wait_data, 1);
      check("R8 hit", qry_fwd_hit, 1);
      check("R8 go low", qry_go, 0);
      check("R3 head not ready", head_ready, 0);
      do_retire(wr, wa, wd);
      settle();
      check("R3 retire ignored head_valid", head_valid, 1);
      check("R3 retire ignored no write", wr, 0);
      do_write(s0, 0, 0, 1, 8'h5A);
      settle();
      check("R8 data after write", qry_data, 8'h5A);
      check("R8 go after write", qry_go, 1);
      check("R3 head ready", head_ready, 1);

      // R6 R9 sweep: every head offset x every older mix on two addresses
      for (int h = 0; h < DEPTH; h++) begin
         for (int pat = 0; pat < 64; pat++) begin
            int exp_k;
            logic [IW-1:0] got;
            do_reset();
            for (int r = 0; r < h; r++) begin
               do_alloc(0, got); do_write(got, 1, 4'h0, 0, 0);
               do_retire(wr, wa, wd);
            end
            exp_k = -1;
            for (int k = 0; k < 3; k++) begin
               int op;
               op = (pat >> (2 * k)) & 3;
               do_alloc(op[1], got);
               if (k == 0) check("R2 R9 wrapped slot", got, h % DEPTH);
               do_write(got, 1, op[0] ? 4'h9 : 4'h3, 1, 8'(8'h40 + 16 * k + h));
               if (op[1] && !op[0]) exp_k = k;
            end
            do_alloc(0, lq);
            do_write(lq, 1, 4'h3, 0, 0);
            qry_idx = lq;
            settle();
            check("R6 R9 hit", qry_fwd_hit, (exp_k >= 0) ? 1 : 0);
            check("R6 R7 data", qry_data, (exp_k >= 0) ? (8'h40 + 16 * exp_k + h) : 8'hC5);
            check("R11 go", qry_go, 1);
         end
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule